// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the date in packed BCD registers. A single-cycle 1 Hz tick input advances it. It holds seconds, minutes, hours, day of month, weekday, month with a century bit, and a two-digit year. Software uses a small word-addressed port to read fields and to load them. While software holds the read strobe, the whole counter chain is held still, so a multi-field read cannot catch a carry partway through. A tick that arrives while the chain is held is kept and applied as soon as the hold ends.

A sticky supply-low flag shares the seconds word. A digital input from an external detector sets the flag. Only a software write clears it. The oscillator, the prescaler, the serial transport and the analog sensing all live outside this block.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds and minutes count 00..59 and hours count 00..23 in packed BCD. Each field wraps to 00 and carries into the next field on the advance after its last value.
- R2: The day of month counts from 01 to the month length and then returns to 01, carrying into the month. The month length is 31, or 30 for months 04, 06, 09 and 11, or for February 29 when the BCD year is divisible by 4 and 28 otherwise. The month counts 01..12 and carries into the year. The year counts 00..99 in BCD.
- R3: The weekday is plain binary 0..6. It increments whenever the day changes through the midnight carry, and it wraps from 6 to 0.
- R4: Bit 7 of register 5 is the century bit. It inverts when the year wraps from 99 to 00, and otherwise changes only through a write.
- R5: Bit 7 of register 0 is the supply-low flag. A cycle with `vlow_in` high sets it. It then stays set until a write to register 0 with bit 7 low.
- R6: While `rd_en` is high and no write occurs, no time field changes, so `rdata` for a fixed address stays constant.
- R7: A tick in a cycle where `rd_en` or `wr_en` is high is held pending. It is applied on the first cycle with both low. Several ticks during one hold count as a single advance.
- R8: The register map is 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year. A write loads the implemented bits of the addressed register directly. Unimplemented bits read 0: seconds and minutes use bits 6:0 (seconds adds bit 7 for the flag), hours and day use 5:0, weekday uses 2:0, month uses 4:0 plus bit 7, and year uses 7:0. Address 7 reads 0.
- R9: After reset all fields read 0 except the supply-low flag, which reads 1, so register 0 reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| vlow_in | input | 1 | Supply-low indication from an external detector |
| rd_en | input | 1 | Read strobe; holds the counters while high |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |

## Verification
The properties assume that software writes only legal BCD values into the time fields. They also assume that `tick_1hz` is a single-cycle pulse. Checks on the year and month carry, and the hold checks, compare held fields across a cycle and do not test digit ranges. The stimulus loads only valid field values before any tick. It pulses the tick for one cycle at a time. The one deliberate write of all-ones, used to probe unimplemented bits, comes after the last advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W   = 8;
    localparam int REG_SEC  = 0;
    localparam int REG_MIN  = 1;
    localparam int REG_HOUR = 2;
    localparam int REG_DAY  = 3;
    localparam int REG_WDAY = 4;
    localparam int REG_MON  = 5;
    localparam int REG_YEAR = 6;

    typedef struct packed {
        logic       vl;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic       cent;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    // Increment a two-digit packed BCD value (no wrap handling)
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic leap_bcd(input logic [7:0] y);
        logic r;
        if (y[4] == 1'b0) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else              r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return r;
    endfunction

    function automatic logic [5:0] month_len_bcd(input logic [4:0] m, input logic [7:0] y);
        logic [5:0] r;
        case (m)
            5'h02:                      r = leap_bcd(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic advance,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        advance = !freeze && (pend_q || tick);
        if (freeze) pend_d = pend_q || tick;
        else        pend_d = pend_q && tick;   // a fresh tick waits behind a pending one
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      adv,
    output rtc_time_t nxt
);
    logic [7:0] sec_i, min_i, hour_i, day_i, mon_i, year_i;
    logic [5:0] mlen;

    always_comb begin
        sec_i  = bcd_inc8({1'b0, cur.sec});
        min_i  = bcd_inc8({1'b0, cur.min});
        hour_i = bcd_inc8({2'b0, cur.hour});
        day_i  = bcd_inc8({2'b0, cur.day});
        mon_i  = bcd_inc8({3'b0, cur.mon});
        year_i = bcd_inc8(cur.year);
        mlen   = month_len_bcd(cur.mon, cur.year);
        nxt    = cur;
        if (adv) begin
            if (cur.sec != 7'h59) begin
                nxt.sec = sec_i[6:0];
            end else begin
                nxt.sec = 7'h00;
                if (cur.min != 7'h59) begin
                    nxt.min = min_i[6:0];
                end else begin
                    nxt.min = 7'h00;
                    if (cur.hour != 6'h23) begin
                        nxt.hour = hour_i[5:0];
                    end else begin
                        nxt.hour = 6'h00;
                        nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
                        if (cur.day != mlen) begin
                            nxt.day = day_i[5:0];
                        end else begin
                            nxt.day = 6'h01;
                            if (cur.mon != 5'h12) begin
                                nxt.mon = mon_i[4:0];
                            end else begin
                                nxt.mon = 5'h01;
                                if (cur.year != 8'h99) begin
                                    nxt.year = year_i;
                                end else begin
                                    nxt.year = 8'h00;
                                    nxt.cent = ~cur.cent;
                                end
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  rtc_time_t           t,
    input  logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        case (int'(addr))
            REG_SEC:  rdata = {t.vl, t.sec};
            REG_MIN:  rdata = {1'b0, t.min};
            REG_HOUR: rdata = {2'b0, t.hour};
            REG_DAY:  rdata = {2'b0, t.day};
            REG_WDAY: rdata = {5'b0, t.wday};
            REG_MON:  rdata = {t.cent, 2'b0, t.mon};
            REG_YEAR: rdata = t.year;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              vlow_in,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    rtc_time_t time_d, time_q, stepped;
    logic      advance, pend_q;
    logic      freeze;

    assign freeze = rd_en || wr_en;

    rtc_tick_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .freeze  (freeze),
        .advance (advance),
        .pend    (pend_q)
    );

    rtc_time_step u_step (
        .cur (time_q),
        .adv (advance),
        .nxt (stepped)
    );

    rtc_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
        .t     (time_q),
        .addr  (addr),
        .rdata (rdata)
    );

    always_comb begin
        time_d = stepped;
        if (wr_en) begin
            case (int'(addr))
                REG_SEC:  begin time_d.vl = wdata[7]; time_d.sec = wdata[6:0]; end
                REG_MIN:  time_d.min  = wdata[6:0];
                REG_HOUR: time_d.hour = wdata[5:0];
                REG_DAY:  time_d.day  = wdata[5:0];
                REG_WDAY: time_d.wday = wdata[2:0];
                REG_MON:  begin time_d.cent = wdata[7]; time_d.mon = wdata[4:0]; end
                REG_YEAR: time_d.year = wdata;
                default:  ;
            endcase
        end
        if (vlow_in) time_d.vl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q    <= '0;
            time_q.vl <= 1'b1;
        end else begin
            time_q <= time_d;
        end
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              vlow_in,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input rtc_time_t         tq,
    input logic              pend
);
    logic [40:0] cal;
    assign cal = {tq.sec, tq.min, tq.hour, tq.day, tq.wday, tq.cent, tq.mon, tq.year};

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> $stable(cal));

    // R5
    vl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_in |=> tq.vl);

    // R5
    vl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq.vl && !(wr_en && addr == '0)) |=> tq.vl);

    // R7
    pend_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && (rd_en || wr_en)) |=> pend);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick_1hz && !pend) |=> $stable(cal));

    // R4
    cent_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(tq.year == 8'h99 && tq.mon == 5'h12)) |=> $stable(tq.cent));

    // R8
    wday_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) == REG_WDAY) |-> (rdata[7:3] == 5'b0));
endmodule

bind bcd_rtc_core rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .vlow_in  (vlow_in),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .tq       (time_q),
    .pend     (pend_q)
);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_1hz = 1'b0;
    logic              vlow_in = 1'b0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bcd_rtc_core #(.ADDR_W(ADDR_W)) u_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .vlow_in(vlow_in),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        #1;
        check(tag, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int d,
                            input int wd, input int mo, input bit c, input int y);
        wr(0, to_bcd(s));
        wr(1, to_bcd(mi));
        wr(2, to_bcd(h));
        wr(3, to_bcd(d));
        wr(4, 8'(wd));
        wr(5, {c, 2'b0, to_bcd(mo)[4:0]});
        wr(6, to_bcd(y));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd_chk("R9 sec", 0, 8'h80);
        for (int a = 1; a < 8; a++) rd_chk("R9 field", a, 8'h00);

        // R5 clear by write
        wr(0, 8'h00);
        rd_chk("R5 cleared", 0, 8'h00);

        // R1 seconds/minute sweep
        set_time(0, 0, 0, 1, 0, 1, 1'b0, 0);
        for (int i = 0; i < 120; i++) begin
            tick();
            rd_chk("R1 sec", 0, to_bcd((i + 1) % 60));
            rd_chk("R1 min", 1, to_bcd((i + 1) / 60));
        end

        // R1 hour carry and R3 weekday wrap
        set_time(59, 59, 22, 5, 6, 3, 1'b0, 21);
        tick();
        rd_chk("R1 hour inc", 2, 8'h23);
        rd_chk("R3 wday hold", 4, 8'h06);
        set_time(59, 59, 23, 5, 6, 3, 1'b0, 21);
        tick();
        rd_chk("R1 hour wrap", 2, 8'h00);
        rd_chk("R1 min wrap", 1, 8'h00);
        rd_chk("R2 day inc", 3, 8'h06);
        rd_chk("R3 wday wrap", 4, 8'h00);
        set_time(59, 59, 23, 9, 2, 3, 1'b0, 21);
        tick();
        rd_chk("R3 wday inc", 4, 8'h03);
        rd_chk("R2 day digit carry", 3, 8'h10);

        // R2 month-end sweep across leap and non-leap years
        for (int y = 0; y < 5; y++) begin
            for (int m = 1; m <= 12; m++) begin
                set_time(59, 59, 23, mdays(m, y), 1, m, 1'b0, y);
                tick();
                rd_chk("R2 day wrap", 3, 8'h01);
                rd_chk("R2 month", 5, to_bcd(m == 12 ? 1 : m + 1));
                rd_chk("R2 year", 6, to_bcd(m == 12 ? y + 1 : y));
            end
        end
        set_time(59, 59, 23, 28, 1, 2, 1'b0, 96);
        tick();
        rd_chk("R2 leap feb 29", 3, 8'h29);

        // R4 century toggles at year wrap
        set_time(59, 59, 23, 31, 1, 12, 1'b0, 99);
        tick();
        rd_chk("R4 cent set", 5, 8'h81);
        rd_chk("R4 year wrap", 6, 8'h00);
        set_time(59, 59, 23, 31, 1, 12, 1'b1, 99);
        tick();
        rd_chk("R4 cent clear", 5, 8'h01);
        set_time(59, 59, 23, 31, 1, 12, 1'b1, 98);
        tick();
        rd_chk("R4 cent kept", 5, 8'h81);
        rd_chk("R4 year inc", 6, 8'h99);

        // R6 / R7 freeze with two ticks collapsing to one
        set_time(10, 20, 5, 7, 3, 4, 1'b0, 30);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(0);
        for (int k = 0; k < 6; k++) begin
            tick_1hz = (k == 1 || k == 3);
            #1;
            check("R6 frozen read", rdata, 8'h10);
            @(negedge clk);
        end
        tick_1hz = 1'b0;
        #1;
        check("R6 frozen read end", rdata, 8'h10);
        rd_en = 1'b0;
        rd_chk("R7 one pending", 0, 8'h11);
        rd_chk("R7 min untouched", 1, 8'h20);

        // R7 tick during a write
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(1); wdata = 8'h07; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        rd_chk("R7 write-deferred tick", 0, 8'h12);
        rd_chk("R8 min loaded", 1, 8'h07);

        // R5 sticky supply-low flag
        @(negedge clk);
        vlow_in = 1'b1;
        @(negedge clk);
        vlow_in = 1'b0;
        rd_chk("R5 flag set", 0, 8'h92);
        tick();
        rd_chk("R5 flag sticky", 0, 8'h93);
        wr(1, 8'h00);
        rd_chk("R5 other write keeps", 0, 8'h93);
        wr(0, 8'h45);
        rd_chk("R5 write clears", 0, 8'h45);

        // R8 unimplemented bits
        for (int a = 0; a < 8; a++) wr(a, 8'hFF);
        rd_chk("R8 sec bits", 0, 8'hFF);
        rd_chk("R8 min bits", 1, 8'h7F);
        rd_chk("R8 hour bits", 2, 8'h3F);
        rd_chk("R8 day bits", 3, 8'h3F);
        rd_chk("R8 wday bits", 4, 8'h07);
        rd_chk("R8 mon bits", 5, 8'h9F);
        rd_chk("R8 year bits", 6, 8'hFF);
        rd_chk("R8 addr7", 7, 8'h00);

        finish_run();
    end
endmodule